// File: doc/BRIEF.md
# Destination-Ordered Sort, Duplicate Trap and Gap Packing Stage

This stage sits between a switch's input ports and a self-routing fabric. Each cycle it takes eight lanes. Each lane carries a valid flag, a 3-bit destination tag and a payload. It rearranges the lanes so that destinations rise from lane 0 upward. The arrival order at the ports cannot be controlled, so the fabric only sees ascending destinations if this stage orders them first.

Ordering is done by a bitonic network of compare-exchange elements. Each element routes the smaller key to its lower lane and the larger key to its upper lane. The key is the inverted valid flag joined to the tag, so empty lanes always end up above every occupied lane. The payload and the valid flag travel with their key through every exchange.

After ordering, a duplicate detector flags every occupied lane whose destination repeats the lane directly below it. Only the first lane of each destination goes on. A packing stage then moves the remaining lanes down to the lowest indices, keeping their order, so the fabric never sees a hole. The ordered lanes and their duplicate flags are also presented, so that flagged packets can be offered again in a later cycle. All outputs are registered, one cycle after the inputs.

Top module: `bsf_front`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output bit is zero.
- R2: On the ordered outputs, the keys {not valid, tag} do not decrease from lane 0 to lane 7. `srt_tag` therefore matches an ascending sort of the input keys exactly, and this includes the tags carried by empty lanes. Lane i of a flat bus occupies bits [i*W +: W].
- R3: `srt_vld` is a thermometer code whose number of ones equals the number of set bits in `in_vld`. Empty lanes sit above all occupied ones.
- R4: Every occupied input lane's (tag, payload) pair appears on exactly one occupied ordered lane. A payload never separates from its tag.
- R5: `srt_trap[i]` is 1 exactly when ordered lane i is occupied, lane i-1 is occupied and the two tags are equal. `srt_trap[0]` is always 0.
- R6: `out_vld` is a thermometer code whose number of ones equals the number of distinct destinations among the occupied inputs. `out_tag` lists those destinations in strictly ascending order.
- R7: Each occupied packed lane carries the payload of the lowest ordered lane with its destination, which is the lane that was not flagged.
- R8: Packed lanes above the survivor count have tag 0 and payload 0.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge, with exactly one register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 8 | Per-lane occupied flag |
| in_tag | input | 24 | Destination tag, 3 bits per lane |
| in_pay | input | 64 | Payload, 8 bits per lane |
| srt_vld | output | 8 | Occupied flags after ordering |
| srt_tag | output | 24 | Tags after ordering |
| srt_pay | output | 64 | Payloads after ordering |
| srt_trap | output | 8 | Duplicate-destination flag per ordered lane |
| out_vld | output | 8 | Occupied flags after packing |
| out_tag | output | 24 | Tags after packing |
| out_pay | output | 64 | Payloads after packing |

## Verification
On every cycle, the assertions check the following:
- both occupied-flag vectors are thermometer codes;
- no flag ever marks an empty lane or lane 0;
- the packed count equals the ordered count minus the flagged count;
- the ordered count matches the input count one cycle earlier.

Only the bench's scenarios can show the rest:
- the exact ascending tag order;
- that payloads stay with their tags;
- which payload survives a duplicate;
- the zeroed lanes above the survivors.

The scenarios used are reversed destinations, all-equal destinations, no traffic, a single lane and random mixes.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
    localparam int LANES   = 8;
    localparam int TAG_W   = $clog2(LANES);
    localparam int PAY_W   = 8;
    localparam int LOG_N   = $clog2(LANES);
    localparam int N_STAGE = LOG_N * (LOG_N + 1) / 2;
    localparam int CNT_W   = LOG_N + 1;

    // Sort key is {empty, tag}: the two most significant fields.
    typedef struct packed {
        logic             empty;
        logic [TAG_W-1:0] tag;
        logic [PAY_W-1:0] pay;
    } lane_t;
endpackage

// File: rtl/bsf_cmp_xchg.sv
module bsf_cmp_xchg
    import bsf_pkg::*;
#(
    parameter bit ASCEND = 1'b1
) (
    input  lane_t a_i,
    input  lane_t b_i,
    output lane_t a_o,
    output lane_t b_o
);
    logic [TAG_W:0] key_a;
    logic [TAG_W:0] key_b;
    logic           swap;

    assign key_a = {a_i.empty, a_i.tag};
    assign key_b = {b_i.empty, b_i.tag};
    assign swap  = ASCEND ? (key_a > key_b) : (key_a < key_b);
    assign a_o   = swap ? b_i : a_i;
    assign b_o   = swap ? a_i : b_i;
endmodule

// File: rtl/bsf_sorter.sv
module bsf_sorter
    import bsf_pkg::*;
(
    input  lane_t lane_i [LANES],
    output lane_t lane_o [LANES]
);
    lane_t st [N_STAGE+1][LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_in
        assign st[0][i]  = lane_i[i];
        assign lane_o[i] = st[N_STAGE][i];
    end

    // Merge phase p builds ordered runs of 2^(p+1); pass d halves the span.
    for (genvar p = 0; p < LOG_N; p++) begin : g_phase
        for (genvar d = 0; d <= p; d++) begin : g_pass
            localparam int SPAN = 1 << (p - d);
            localparam int BLK  = 2 << p;
            localparam int SIDX = p * (p + 1) / 2 + d;
            for (genvar i = 0; i < LANES; i++) begin : g_lane
                if ((i & SPAN) == 0) begin : g_ce
                    bsf_cmp_xchg #(.ASCEND((i & BLK) == 0)) u_ce (
                        .a_i(st[SIDX][i]),
                        .b_i(st[SIDX][i | SPAN]),
                        .a_o(st[SIDX+1][i]),
                        .b_o(st[SIDX+1][i | SPAN])
                    );
                end
            end
        end
    end
endmodule

// File: rtl/bsf_trap.sv
module bsf_trap
    import bsf_pkg::*;
(
    input  lane_t            lane_i [LANES],
    output logic [LANES-1:0] trap_o
);
    assign trap_o[0] = 1'b0;
    for (genvar i = 1; i < LANES; i++) begin : g_dup
        assign trap_o[i] = !lane_i[i].empty && !lane_i[i-1].empty
                         && (lane_i[i].tag == lane_i[i-1].tag);
    end
endmodule

// File: rtl/bsf_concentrator.sv
module bsf_concentrator
    import bsf_pkg::*;
(
    input  lane_t            lane_i [LANES],
    input  logic [LANES-1:0] trap_i,
    output lane_t            lane_o [LANES]
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_o[k] = '{empty: 1'b1, tag: '0, pay: '0};
        end
        for (int i = 0; i < LANES; i++) begin
            if (!lane_i[i].empty && !trap_i[i]) begin
                lane_o[cnt[LOG_N-1:0]] = lane_i[i];
                cnt = cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsf_front.sv
module bsf_front
    import bsf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       in_vld,
    input  logic [LANES*TAG_W-1:0] in_tag,
    input  logic [LANES*PAY_W-1:0] in_pay,
    output logic [LANES-1:0]       srt_vld,
    output logic [LANES*TAG_W-1:0] srt_tag,
    output logic [LANES*PAY_W-1:0] srt_pay,
    output logic [LANES-1:0]       srt_trap,
    output logic [LANES-1:0]       out_vld,
    output logic [LANES*TAG_W-1:0] out_tag,
    output logic [LANES*PAY_W-1:0] out_pay
);
    lane_t            raw    [LANES];
    lane_t            sorted [LANES];
    lane_t            packed_l [LANES];
    logic [LANES-1:0] trap;

    logic [LANES-1:0]       nx_svld, nx_ovld;
    logic [LANES*TAG_W-1:0] nx_stag, nx_otag;
    logic [LANES*PAY_W-1:0] nx_spay, nx_opay;

    for (genvar i = 0; i < LANES; i++) begin : g_io
        assign raw[i].empty = !in_vld[i];
        assign raw[i].tag   = in_tag[i*TAG_W +: TAG_W];
        assign raw[i].pay   = in_pay[i*PAY_W +: PAY_W];

        assign nx_svld[i]                 = !sorted[i].empty;
        assign nx_stag[i*TAG_W +: TAG_W]  = sorted[i].tag;
        assign nx_spay[i*PAY_W +: PAY_W]  = sorted[i].pay;
        assign nx_ovld[i]                 = !packed_l[i].empty;
        assign nx_otag[i*TAG_W +: TAG_W]  = packed_l[i].tag;
        assign nx_opay[i*PAY_W +: PAY_W]  = packed_l[i].pay;
    end

    bsf_sorter u_sort (
        .lane_i(raw),
        .lane_o(sorted)
    );

    bsf_trap u_trap (
        .lane_i(sorted),
        .trap_o(trap)
    );

    bsf_concentrator u_conc (
        .lane_i(sorted),
        .trap_i(trap),
        .lane_o(packed_l)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srt_vld  <= '0;
            srt_tag  <= '0;
            srt_pay  <= '0;
            srt_trap <= '0;
            out_vld  <= '0;
            out_tag  <= '0;
            out_pay  <= '0;
        end else begin
            srt_vld  <= nx_svld;
            srt_tag  <= nx_stag;
            srt_pay  <= nx_spay;
            srt_trap <= trap;
            out_vld  <= nx_ovld;
            out_tag  <= nx_otag;
            out_pay  <= nx_opay;
        end
    end

    // R3: empty ordered lanes sit above all occupied ones
    p_srt_thermo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (srt_vld & (srt_vld + 1'b1)) == '0);

    // R9: one register stage between input count and ordered count
    p_count_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $countones(srt_vld) == $countones($past(in_vld)));

    // R5: flags only on occupied lanes, never on lane 0
    p_trap_occupied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((srt_trap & ~srt_vld) == '0) && !srt_trap[0]);

    // R6: packed lanes form a thermometer code
    p_out_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld & (out_vld + 1'b1)) == '0);

    // R6: survivors equal ordered occupants minus flagged ones
    p_out_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_vld) == $countones(srt_vld) - $countones(srt_trap));
endmodule

// File: tb/bsf_front_tb.sv
module bsf_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  in_vld;
    logic [23:0] in_tag;
    logic [63:0] in_pay;
    logic [7:0]  srt_vld, srt_trap, out_vld;
    logic [23:0] srt_tag, out_tag;
    logic [63:0] srt_pay, out_pay;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4ns clk = ~clk;  // 125 MHz

    bsf_front dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_tag(in_tag), .in_pay(in_pay),
        .srt_vld(srt_vld), .srt_tag(srt_tag), .srt_pay(srt_pay),
        .srt_trap(srt_trap),
        .out_vld(out_vld), .out_tag(out_tag), .out_pay(out_pay)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [7:0] v, input logic [23:0] t, input logic [63:0] p);
        int          key [8];
        logic [7:0]  e_svld, e_trap, e_ovld;
        logic [23:0] e_stag, e_otag;
        logic [63:0] e_opay;
        int          nsurv;
        bit          found;
        bit          all_found;
        in_vld = v; in_tag = t; in_pay = p;
        @(negedge clk);  // one edge later (R9)
        for (int i = 0; i < 8; i++) key[i] = (v[i] ? 0 : 8) + int'(t[i*3 +: 3]);
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 7 - a; b++)
                if (key[b] > key[b+1]) begin
                    int tmp = key[b]; key[b] = key[b+1]; key[b+1] = tmp;
                end
        e_svld = '0; e_stag = '0; e_trap = '0;
        e_ovld = '0; e_otag = '0; e_opay = '0;
        nsurv  = 0;
        for (int i = 0; i < 8; i++) begin
            e_svld[i] = key[i] < 8;
            e_stag[i*3 +: 3] = 3'(key[i] % 8);
            if (i > 0 && key[i] < 8 && key[i] == key[i-1]) e_trap[i] = 1'b1;
            else if (key[i] < 8) begin
                e_ovld[nsurv] = 1'b1;
                e_otag[nsurv*3 +: 3] = 3'(key[i]);
                // R7: payload of the lowest ordered lane with this destination
                e_opay[nsurv*8 +: 8] = srt_pay[i*8 +: 8];
                nsurv++;
            end
        end
        chk("R3 srt_vld", 64'(srt_vld), 64'(e_svld));
        chk("R2 srt_tag", 64'(srt_tag), 64'(e_stag));
        chk("R5 srt_trap", 64'(srt_trap), 64'(e_trap));
        chk("R6 out_vld", 64'(out_vld), 64'(e_ovld));
        chk("R6 out_tag", 64'(out_tag), 64'(e_otag));
        chk("R7 R8 out_pay", out_pay, e_opay);
        // R4: each occupied (tag, payload) pair is found on an occupied ordered lane
        all_found = 1'b1;
        for (int j = 0; j < 8; j++) if (v[j]) begin
            found = 1'b0;
            for (int i = 0; i < 8; i++)
                if (srt_vld[i] && srt_tag[i*3 +: 3] == t[j*3 +: 3] && srt_pay[i*8 +: 8] == p[j*8 +: 8])
                    found = 1'b1;
            if (!found) all_found = 1'b0;
        end
        chk("R4 payload follows tag", 64'(all_found), 64'd1);
    endtask

    function automatic logic [63:0] mk_pay(input int base);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = 8'(base * 8 + i);
        return r;
    endfunction

    initial begin
        #800us;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_vld = '0; in_tag = '0; in_pay = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset
        chk("R1 reset srt", {srt_vld, srt_trap, out_vld, srt_tag, out_tag}, 64'd0);
        chk("R1 reset pay", srt_pay | out_pay, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {srt_vld, srt_trap, out_vld, srt_tag, out_tag}, 64'd0);
        // reversed distinct destinations
        run_vec(8'hFF, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, mk_pay(1));
        // all lanes to one destination (R5)
        run_vec(8'hFF, {8{3'd5}}, mk_pay(2));
        // no traffic (R8)
        run_vec(8'h00, 24'hABCDEF, mk_pay(3));
        // single occupied lane, high index
        run_vec(8'h80, {3'd2, 21'd0}, mk_pay(4));
        // gaps plus duplicates
        run_vec(8'b1010_0110, {3'd3,3'd1,3'd3,3'd7,3'd0,3'd1,3'd1,3'd6}, mk_pay(5));
        for (int n = 0; n < 60; n++)
            run_vec(8'($urandom), 24'($urandom), mk_pay(6 + n));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule